// File: doc/BRIEF.md
# Two-Stage Deflection Arbitration Network

This block is the combinational routing core of a four-port mesh deflection router. Each cycle it accepts up to four flits, one from each of the North, East, South and West links. It places every valid flit on a distinct output link, so nothing is ever held back. A flit that loses arbitration is sent out on some other link. Each flit carries a valid bit, a requested direction, a golden flag, a sequence number and a payload. The block adds a silver mark of its own to one valid flit every cycle.

The permutation is built from four 2x2 arbiter cells arranged in two stages. The first stage pairs the inputs (North, East) and (South, West). Each first-stage cell sends its winner to the second-stage cell that owns the winner's requested pair, either (North, South) or (East, West). The loser goes to the other second-stage cell. Each cell decides alone, in this order of precedence:

1. A golden flit beats a non-golden one.
2. Between two golden flits, the lower sequence number wins.
3. A silver flit beats a plain one.
4. Otherwise the winner is chosen by a pseudo-random bit.

A free-running 16-bit LFSR, reloaded with a fixed seed at reset, supplies the tie-break bits and the starting point for the silver choice.

Top module: `defl_perm_net`

## Requirements
- R1: Every valid input flit appears on exactly one output, with its payload, sequence number, golden flag and requested direction unchanged. The number of valid outputs equals the number of valid inputs.
- R2: When no input is valid, every out_valid and out_silver bit is 0, including in the first cycle after reset.
- R3: Whenever at least one input is valid, exactly one valid output carries out_silver = 1, and no invalid output carries it.
- R4: When exactly one valid input is golden, that flit leaves on the output indexed by its requested direction.
- R5: When several valid inputs are golden and have distinct sequence numbers, the golden flit with the lowest sequence number leaves on its requested output.
- R6: When no valid input is golden, the silver flit leaves on its requested output (out_dir[j] == j for the silver output j).
- R7: Directions are encoded North=0, East=1, South=2, West=3, and output index j is the link with code j. A lone valid flit on any input leaves on the output equal to its requested direction.
- R8: After reset, the same input sequence always yields the same output sequence.
- R9: In the following case, the silver flit leaves on North and the other flit leaves on East:
  - North and East inputs are both valid and both request North;
  - neither is golden;
  - South and West are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the LFSR |
| rst_n | input | 1 | Synchronous active-low reset; reloads the LFSR seed |
| in_valid | input | 4 | Per-input flit present (index = N,E,S,W) |
| in_dir | input | 4x2 | Requested output direction per input |
| in_golden | input | 4 | Flit belongs to the golden packet |
| in_seq | input | 4xSEQ_W | Sequence number within the golden order |
| in_data | input | 4xDATA_W | Flit payload |
| out_valid | output | 4 | Flit present on each output link |
| out_dir | output | 4x2 | Requested direction of the flit on each output |
| out_golden | output | 4 | Golden flag of the flit on each output |
| out_silver | output | 4 | Silver mark of the flit on each output |
| out_seq | output | 4xSEQ_W | Sequence number of the flit on each output |
| out_data | output | 4xDATA_W | Payload of the flit on each output |

## Verification
The hardest case to reach from the ports is a pair of golden flits that meet in a second-stage cell after coming through different first-stage cells. Only there does the sequence-number comparison decide between two flits that have both already won once. The stimulus table sets this up by making every input golden with scattered sequence numbers and the same requested output. Because the silver choice and tie-breaks come from the LFSR, the North/East contention pattern is repeated over several consecutive cycles so that different silver picks are seen. A whole table pass is then replayed after a second reset and compared output for output.

// File: rtl/defl_pkg.sv
// Package: shared constants and direction codes for the deflection
// arbitration network. Assumes a four-port mesh router.
package defl_pkg;
    localparam int NUM_PORTS = 4;
    localparam int DIR_W     = 2;

    typedef enum logic [DIR_W-1:0] {
        DIR_NORTH = 2'd0,
        DIR_EAST  = 2'd1,
        DIR_SOUTH = 2'd2,
        DIR_WEST  = 2'd3
    } dir_e;
endpackage

// File: rtl/defl_lfsr.sv
// Module: Galois LFSR, free running, reloaded with SEED on synchronous
// active-low reset. Assumes TAPS describes a maximal-length polynomial
// and SEED is nonzero.
module defl_lfsr #(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS = 16'hB400,
    parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] state
);
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    // Next state: shift right, fold taps in when the dropped bit is 1.
    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) state_d = state_d ^ TAPS;
    end

    // State register with seed reload.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/defl_silver_pick.sv
// Module: marks exactly one valid input as silver. The search starts at
// a pseudo-random index and rotates to the first valid input. Assumes
// NUM is a power of two. Output is all zero when no input is valid.
module defl_silver_pick #(
    parameter int NUM = 4,
    localparam int IDX_W = $clog2(NUM)
) (
    input  logic [NUM-1:0]   valid,
    input  logic [IDX_W-1:0] start,
    output logic [NUM-1:0]   silver
);
    // Rotating first-valid search from the random start point.
    always_comb begin
        logic found;
        logic [IDX_W-1:0] idx;
        silver = '0;
        found  = 1'b0;
        for (int k = 0; k < NUM; k++) begin
            idx = start + IDX_W'(k);
            if (!found && valid[idx]) begin
                silver[idx] = 1'b1;
                found       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/defl_cell.sv
// Module: 2x2 arbiter cell. It picks a winner and steers it to the side
// named by bit SIDE_BIT of its requested direction; the loser takes the
// other side. Precedence: invalid always loses, then golden, then lower
// sequence number among golden, then silver, then the random bit.
// Flit layout (lsb first): valid, dir[1:0], golden, silver, seq, data.
module defl_cell #(
    parameter int DATA_W   = 16,
    parameter int SEQ_W    = 4,
    parameter int SIDE_BIT = 0,
    localparam int VAL_B   = 0,
    localparam int DIR_LO  = 1,
    localparam int GLD_B   = 3,
    localparam int SLV_B   = 4,
    localparam int SEQ_LO  = 5,
    localparam int FLIT_W  = SEQ_LO + SEQ_W + DATA_W
) (
    input  logic [FLIT_W-1:0] in_a,
    input  logic [FLIT_W-1:0] in_b,
    input  logic              rnd,
    output logic [FLIT_W-1:0] out_lo,
    output logic [FLIT_W-1:0] out_hi
);
    logic             a_wins;
    logic [FLIT_W-1:0] win;
    logic [FLIT_W-1:0] lose;
    logic [SEQ_W-1:0]  seq_a;
    logic [SEQ_W-1:0]  seq_b;
    logic              side;

    assign seq_a = in_a[SEQ_LO +: SEQ_W];
    assign seq_b = in_b[SEQ_LO +: SEQ_W];

    // Priority decision between the two inputs.
    always_comb begin
        if (!in_a[VAL_B])                         a_wins = 1'b0;
        else if (!in_b[VAL_B])                    a_wins = 1'b1;
        else if (in_a[GLD_B] != in_b[GLD_B])      a_wins = in_a[GLD_B];
        else if (in_a[GLD_B])                     a_wins = (seq_a <= seq_b);
        else if (in_a[SLV_B] != in_b[SLV_B])      a_wins = in_a[SLV_B];
        else                                      a_wins = rnd;
    end

    // Winner and loser selection.
    always_comb begin
        win  = a_wins ? in_a : in_b;
        lose = a_wins ? in_b : in_a;
    end

    assign side = win[DIR_LO + SIDE_BIT];

    // Steering: winner to its side, loser to the remaining side.
    always_comb begin
        out_lo = side ? lose : win;
        out_hi = side ? win  : lose;
    end
endmodule

// File: rtl/defl_perm_net.sv
// Module: top of the two-stage deflection permutation network. Stage one
// pairs inputs (N,E) and (S,W) and steers on direction bit 0 toward the
// (N,S) or (E,W) second-stage cell; stage two steers on direction bit 1.
// Purely combinational from inputs and LFSR state; the LFSR advances
// every cycle. Assumes golden flits carry distinct sequence numbers.
module defl_perm_net
    import defl_pkg::*;
#(
    parameter int              DATA_W    = 16,
    parameter int              SEQ_W     = 4,
    parameter int              LFSR_W    = 16,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS-1:0]              in_valid,
    input  logic [NUM_PORTS-1:0][DIR_W-1:0]   in_dir,
    input  logic [NUM_PORTS-1:0]              in_golden,
    input  logic [NUM_PORTS-1:0][SEQ_W-1:0]   in_seq,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  in_data,
    output logic [NUM_PORTS-1:0]              out_valid,
    output logic [NUM_PORTS-1:0][DIR_W-1:0]   out_dir,
    output logic [NUM_PORTS-1:0]              out_golden,
    output logic [NUM_PORTS-1:0]              out_silver,
    output logic [NUM_PORTS-1:0][SEQ_W-1:0]   out_seq,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]  out_data
);
    localparam int IDX_W   = $clog2(NUM_PORTS);
    localparam int NCELL   = NUM_PORTS / 2;
    localparam int SEQ_LO  = 5;
    localparam int FLIT_W  = SEQ_LO + SEQ_W + DATA_W;

    logic [LFSR_W-1:0]              lfsr_q;
    logic [NUM_PORTS-1:0]           silver_mask;
    logic [NUM_PORTS-1:0][FLIT_W-1:0] flit_in;
    logic [NCELL-1:0][1:0][FLIT_W-1:0] s1_out;
    logic [NUM_PORTS-1:0][FLIT_W-1:0] flit_out;

    defl_lfsr #(
        .WIDTH (LFSR_W),
        .TAPS  (LFSR_TAPS),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_q)
    );

    defl_silver_pick #(
        .NUM    (NUM_PORTS)
    ) u_silver (
        .valid  (in_valid),
        .start  (lfsr_q[NCELL*2 +: IDX_W]),
        .silver (silver_mask)
    );

    // Pack each input port into a flit word.
    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pack
            assign flit_in[p] = {in_data[p], in_seq[p], silver_mask[p],
                                 in_golden[p], in_dir[p], in_valid[p]};
        end
    endgenerate

    // Stage one: cell g serves inputs 2g and 2g+1, steering on dir bit 0.
    generate
        for (genvar g = 0; g < NCELL; g++) begin : g_stage1
            defl_cell #(
                .DATA_W   (DATA_W),
                .SEQ_W    (SEQ_W),
                .SIDE_BIT (0)
            ) u_cell (
                .in_a   (flit_in[2*g]),
                .in_b   (flit_in[2*g+1]),
                .rnd    (lfsr_q[g]),
                .out_lo (s1_out[g][0]),
                .out_hi (s1_out[g][1])
            );
        end
    endgenerate

    // Stage two: cell h owns outputs h and h+2, steering on dir bit 1.
    generate
        for (genvar h = 0; h < NCELL; h++) begin : g_stage2
            defl_cell #(
                .DATA_W   (DATA_W),
                .SEQ_W    (SEQ_W),
                .SIDE_BIT (1)
            ) u_cell (
                .in_a   (s1_out[0][h]),
                .in_b   (s1_out[1][h]),
                .rnd    (lfsr_q[NCELL + h]),
                .out_lo (flit_out[h]),
                .out_hi (flit_out[h + NCELL])
            );
        end
    endgenerate

    // Unpack output flit words onto the output ports.
    generate
        for (genvar q = 0; q < NUM_PORTS; q++) begin : g_unpack
            assign out_valid[q]  = flit_out[q][0];
            assign out_dir[q]    = flit_out[q][2:1];
            assign out_golden[q] = flit_out[q][3] & flit_out[q][0];
            assign out_silver[q] = flit_out[q][4] & flit_out[q][0];
            assign out_seq[q]    = flit_out[q][SEQ_LO +: SEQ_W];
            assign out_data[q]   = flit_out[q][SEQ_LO + SEQ_W +: DATA_W];
        end
    endgenerate
endmodule

// File: rtl/defl_perm_net_chk.sv
// Module: assertion checker for defl_perm_net, attached by bind below.
// Samples the combinational outputs at each rising edge after reset.
module defl_perm_net_chk #(
    parameter int DATA_W = 16,
    parameter int SEQ_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       in_valid,
    input logic [3:0][1:0]  in_dir,
    input logic [3:0]       in_golden,
    input logic [3:0]       out_valid,
    input logic [3:0][1:0]  out_dir,
    input logic [3:0]       out_silver
);
    // R1
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid) == $countones(in_valid));

    // R2
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid == 4'b0) |-> (out_valid == 4'b0 && out_silver == 4'b0));

    // R3
    one_silver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid != 4'b0) |->
            ($countones(out_silver & out_valid) == 1 && (out_silver & ~out_valid) == 4'b0));

    generate
        for (genvar i = 0; i < 4; i++) begin : g_port
            // R4
            golden_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid[i] && in_golden[i] && $countones(in_valid & in_golden) == 1)
                    |-> (out_valid[in_dir[i]] && out_dir[in_dir[i]] == in_dir[i]));

            // R6
            silver_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((in_valid & in_golden) == 4'b0 && out_valid[i] && out_silver[i])
                    |-> (out_dir[i] == 2'(i)));
        end
    endgenerate
endmodule

bind defl_perm_net defl_perm_net_chk #(
    .DATA_W (DATA_W),
    .SEQ_W  (SEQ_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_dir     (in_dir),
    .in_golden  (in_golden),
    .out_valid  (out_valid),
    .out_dir    (out_dir),
    .out_silver (out_silver)
);

// File: tb/defl_perm_net_tb.sv
module defl_perm_net_tb;
    localparam int DATA_W = 16;
    localparam int SEQ_W  = 4;
    localparam int NVEC   = 14;

    // Vector layout: [31:28] valid, [27:24] golden, [23:16] dirs (2b/port),
    // [15:0] seq numbers (4b/port), port 0 in the low bits.
    localparam logic [31:0] VEC [NVEC] = '{
        32'hF0E40000, 32'hF0000000, 32'hFFAA4179, 32'hF2FF0000,
        32'h80000000, 32'h10030000, 32'h99412005, 32'h30000000,
        32'hC0500000, 32'hF500000F, 32'h702F0000, 32'h00000000,
        32'hF0DD0000, 32'hF8AA0000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]             in_valid = '0;
    logic [3:0][1:0]        in_dir = '0;
    logic [3:0]             in_golden = '0;
    logic [3:0][SEQ_W-1:0]  in_seq = '0;
    logic [3:0][DATA_W-1:0] in_data = '0;
    logic [3:0]             out_valid;
    logic [3:0][1:0]        out_dir;
    logic [3:0]             out_golden;
    logic [3:0]             out_silver;
    logic [3:0][SEQ_W-1:0]  out_seq;
    logic [3:0][DATA_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    logic [3:0][DATA_W-1:0] rec_data [NVEC];
    logic [3:0]             rec_silver [NVEC];

    always #2 clk = ~clk;

    defl_perm_net #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_dir(in_dir), .in_golden(in_golden),
        .in_seq(in_seq), .in_data(in_data),
        .out_valid(out_valid), .out_dir(out_dir), .out_golden(out_golden),
        .out_silver(out_silver), .out_seq(out_seq), .out_data(out_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        in_valid = '0; in_golden = '0; in_dir = '0; in_seq = '0; in_data = '0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    task automatic drive_vec(input int v);
        logic [31:0] w;
        w = VEC[v];
        @(posedge clk); #1;
        in_valid  = w[31:28];
        in_golden = w[27:24];
        for (int p = 0; p < 4; p++) begin
            in_dir[p]  = w[16 + 2*p +: 2];
            in_seq[p]  = w[4*p +: 4];
            in_data[p] = 16'hA000 | DATA_W'(v << 4) | DATA_W'(p);
        end
        #2;
    endtask

    task automatic eval_vec(input int v);
        bit ok;
        int hits;
        int best;
        int sil;
        ok = ($countones(out_valid) == $countones(in_valid));
        for (int p = 0; p < 4; p++) begin
            if (in_valid[p]) begin
                hits = 0;
                for (int j = 0; j < 4; j++)
                    if (out_valid[j] && out_data[j] == in_data[p] && out_seq[j] == in_seq[p] &&
                        out_golden[j] == in_golden[p] && out_dir[j] == in_dir[p]) hits++;
                if (hits != 1) ok = 0;
            end
        end
        check(ok, $sformatf("R1 conservation vec %0d", v), 64'(out_valid), 64'(in_valid));
        if (in_valid == 4'b0) begin
            check(out_valid == 4'b0 && out_silver == 4'b0, $sformatf("R2 idle vec %0d", v),
                  64'({out_valid, out_silver}), 64'h0);
        end else begin
            check($countones(out_silver & out_valid) == 1 && (out_silver & ~out_valid) == 0,
                  $sformatf("R3 silver vec %0d", v), 64'({out_valid, out_silver}), 64'h1);
            best = -1;
            for (int p = 0; p < 4; p++)
                if (in_valid[p] && in_golden[p] && (best < 0 || in_seq[p] < in_seq[best])) best = p;
            if (best >= 0) begin
                check(out_valid[in_dir[best]] && out_data[in_dir[best]] == in_data[best],
                      $sformatf("%s golden vec %0d", ($countones(in_valid & in_golden) > 1) ? "R5" : "R4", v),
                      64'(out_data[in_dir[best]]), 64'(in_data[best]));
            end else begin
                sil = 0;
                for (int j = 0; j < 4; j++) if (out_silver[j] && out_valid[j]) sil = j;
                check(out_dir[sil] == 2'(sil), $sformatf("R6 silver path vec %0d", v),
                      64'(out_dir[sil]), 64'(sil));
            end
        end
    endtask

    task automatic run_table(input int pass);
        for (int v = 0; v < NVEC; v++) begin
            drive_vec(v);
            eval_vec(v);
            if (pass == 0) begin
                rec_data[v]   = out_data;
                rec_silver[v] = out_silver;
            end else begin
                check(rec_data[v] == out_data && rec_silver[v] == out_silver,
                      $sformatf("R8 replay vec %0d", v), 64'(out_silver), 64'(rec_silver[v]));
            end
        end
    endtask

    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        #2;
        // R2: reset state with no inputs
        check(out_valid == 4'b0 && out_silver == 4'b0, "R2 reset state",
              64'({out_valid, out_silver}), 64'h0);

        run_table(0);
        do_reset();
        run_table(1);

        // R7: lone flit from each input to each direction
        for (int p = 0; p < 4; p++) begin
            for (int d = 0; d < 4; d++) begin
                @(posedge clk); #1;
                in_valid = 4'(1 << p); in_golden = '0; in_dir = '0; in_seq = '0;
                in_dir[p] = 2'(d);
                in_data[p] = 16'h5000 | DATA_W'(p << 4) | DATA_W'(d);
                #2;
                check(out_valid == 4'(1 << d) && out_data[d] == in_data[p],
                      $sformatf("R7 lone flit port %0d dir %0d", p, d),
                      64'({out_valid, out_data[d]}), 64'({4'(1 << d), in_data[p]}));
            end
        end

        // R9: N and E both want N, rest empty, across several LFSR states
        for (int c = 0; c < 8; c++) begin
            @(posedge clk); #1;
            in_valid = 4'b0011; in_golden = '0; in_dir = '0; in_seq = '0;
            in_data[0] = 16'h9000 | DATA_W'(c);
            in_data[1] = 16'h9100 | DATA_W'(c);
            #2;
            check(out_valid == 4'b0011 && out_silver == 4'b0001 &&
                  ((out_data[0] == in_data[0] && out_data[1] == in_data[1]) ||
                   (out_data[0] == in_data[1] && out_data[1] == in_data[0])),
                  $sformatf("R9 NE contention cycle %0d", c),
                  64'({out_valid, out_silver}), 64'({4'b0011, 4'b0001}));
        end

        @(posedge clk); #1;
        in_valid = '0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule